// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block produces the interrupt identification byte and the interrupt request line of a 16550-style serial port. It watches five interrupt sources (receiver line status, receive character timeout, receive data available, transmitter holding register empty and modem status delta) and reports the highest-priority active one as a 4-bit code. When the FIFOs are on, the upper two bits of the byte read as ones.

When the receive FIFO is on, the receive-data source is gated by the programmed trigger level. A character-timeout source ranks just below line status.

The block keeps one piece of state: the hidden transmit-empty pending flag. Reading the identification register clears it. Writing the enable register while the holding register is empty sets it again, and so does the transmit path when it drains. The FIFOs, the shifter, the baud timing and the bus decode sit outside. They drive the inputs as plain signals and strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: Sources are ranked, highest first: line status, character timeout, receive data, transmit empty, modem status. Only the highest active source is reported.
- R2: The identification code in bits 3:0 is 0x1 when no source is active, 0x6 for line status, 0xC for character timeout, 0x4 for receive data, 0x2 for transmit empty and 0x0 for modem status.
- R3: The line status source is active when enable bit 2 is set and any of `line_stat[4:1]` is set. `line_stat[0]` and `line_stat[5]` never activate it.
- R4: The receive data source needs enable bit 0 and `line_stat[0]` (data ready). With the FIFO on it also needs `rx_count >= rx_trig`. Below the trigger level it is inactive, and a lower source may then be reported.
- R5: Bits 7:6 of `id_byte` are 11 when `fifo_on` is high and 00 when it is low. Bits 5:4 are always 0.
- R6: `irq` is high exactly when `out_en` is high and `id_byte[0]` is 0. Driving `out_en` low forces `irq` low and leaves `id_byte` unchanged.
- R7: An `iir_rd` strobe clears the transmit-empty pending flag. The change shows in `id_byte` from the cycle after the strobe.
- R8: An `ier_wr` strobe sets the pending flag on the next cycle when `line_stat[5]` (holding register empty) is high. It has no effect when `line_stat[5]` is low.
- R9: A `tx_drain` strobe sets the pending flag and a `thr_wr` strobe clears it, each taking effect on the next cycle. When a set and a clear arrive in the same cycle, the set wins.
- R10: The modem status source is active when enable bit 3 is set and any of `modem_delta[3:0]` is set.
- R11: The transmit-empty source is active when enable bit 1 and the pending flag are both set.
- R12: The character-timeout source follows `tmo_pend` and does not depend on any enable bit.
- R13: After reset the pending flag is clear. With all source inputs low, `id_byte` reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 4 | Interrupt enables: bit0 receive data, bit1 transmit empty, bit2 line status, bit3 modem status |
| line_stat | input | 6 | bit0 data ready, bits 4:1 error/break flags, bit5 holding register empty |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive trigger level in bytes |
| fifo_on | input | 1 | FIFOs enabled |
| tmo_pend | input | 1 | Character timeout pending |
| modem_delta | input | 4 | Modem status delta bits |
| out_en | input | 1 | Global interrupt output enable |
| iir_rd | input | 1 | One-cycle strobe: identification register read |
| ier_wr | input | 1 | One-cycle strobe: enable register written |
| thr_wr | input | 1 | One-cycle strobe: holding register written |
| tx_drain | input | 1 | One-cycle strobe: transmit path became empty |
| id_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The identification byte and `irq` follow the level inputs in the same cycle, because no register lies on that path. The bench therefore drives each table vector just after a falling edge and samples 1 ns later, before the next rising edge. The four strobes act through the pending flag, so their effect is due one rising edge after the strobe. For these, the bench first confirms that the code has not yet changed while the strobe is high. It then samples after the following falling edge, which falls after exactly one capturing edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC = 5;

  // Source index order equals priority order, index 0 highest
  localparam int SRC_LINE = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MDM  = 4;

  // Enable bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = CODE_LINE;
      SRC_TMO:  src_code = CODE_TMO;
      SRC_RXD:  src_code = CODE_RXD;
      SRC_THRE: src_code = CODE_THRE;
      default:  src_code = CODE_MDM;
    endcase
  endfunction
endpackage

// File: rtl/uirq_thre_flag.sv
module uirq_thre_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic iir_rd,
  input  logic ier_wr,
  input  logic thr_empty,
  input  logic tx_drain,
  input  logic thr_wr,
  output logic pend
);
  logic set_evt, clr_evt, pend_nxt;

  always_comb begin
    set_evt  = tx_drain | (ier_wr & thr_empty);
    clr_evt  = iir_rd | thr_wr;
    pend_nxt = pend;
    if (clr_evt) pend_nxt = 1'b0;
    if (set_evt) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (set_evt | clr_evt)  pend <= pend_nxt;
  end

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !tx_drain && !(ier_wr && thr_empty)) |=> !pend);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thr_empty) |=> pend);

  // R9
  drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drain |=> pend);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iir_rd && !ier_wr && !thr_wr && !tx_drain) |=> $stable(pend));
endmodule

// File: rtl/uirq_sources.sv
module uirq_sources
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]         int_en,
  input  logic [4:0]         lsr_lo,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic               fifo_on,
  input  logic               tmo_pend,
  input  logic               thre_pend,
  input  logic [3:0]         modem_delta,
  output logic [NUM_SRC-1:0] src_act
);
  logic rx_level_ok;

  always_comb begin
    rx_level_ok        = !fifo_on || (rx_count >= rx_trig);
    src_act            = '0;
    src_act[SRC_LINE]  = int_en[EN_LINE] && (|lsr_lo[4:1]);
    src_act[SRC_TMO]   = tmo_pend;
    src_act[SRC_RXD]   = int_en[EN_RXD] && lsr_lo[0] && rx_level_ok;
    src_act[SRC_THRE]  = int_en[EN_THRE] && thre_pend;
    src_act[SRC_MDM]   = int_en[EN_MDM] && (|modem_delta);
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] src_act,
  output logic [3:0]   code
);
  always_comb begin
    code = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (src_act[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       int_en,
  input  logic [5:0]       line_stat,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             fifo_on,
  input  logic             tmo_pend,
  input  logic [3:0]       modem_delta,
  input  logic             out_en,
  input  logic             iir_rd,
  input  logic             ier_wr,
  input  logic             thr_wr,
  input  logic             tx_drain,
  output logic [7:0]       id_byte,
  output logic             irq
);
  logic               thre_pend;
  logic [NUM_SRC-1:0] src_act;
  logic [3:0]         code;

  uirq_thre_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .iir_rd    (iir_rd),
    .ier_wr    (ier_wr),
    .thr_empty (line_stat[5]),
    .tx_drain  (tx_drain),
    .thr_wr    (thr_wr),
    .pend      (thre_pend)
  );

  uirq_sources #(.CNT_W(CNT_W)) u_src (
    .int_en      (int_en),
    .lsr_lo      (line_stat[4:0]),
    .rx_count    (rx_count),
    .rx_trig     (rx_trig),
    .fifo_on     (fifo_on),
    .tmo_pend    (tmo_pend),
    .thre_pend   (thre_pend),
    .modem_delta (modem_delta),
    .src_act     (src_act)
  );

  uirq_prio #(.N(NUM_SRC)) u_prio (
    .src_act (src_act),
    .code    (code)
  );

  always_comb begin
    id_byte = {{2{fifo_on}}, 2'b00, code};
    irq     = out_en & ~code[0];
  end

  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_act[SRC_LINE] |-> (id_byte[3:0] == CODE_LINE));

  // R1
  tmo_over_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_act[SRC_LINE] && src_act[SRC_TMO]) |-> (id_byte[3:0] == CODE_TMO));

  // R2
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_act == '0) |-> (id_byte[3:0] == CODE_NONE));

  // R6
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (src_act != '0));
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] int_en = '0;
  logic [5:0] line_stat = '0;
  logic [4:0] rx_count = '0;
  logic [4:0] rx_trig = '0;
  logic       fifo_on = 1'b0;
  logic       tmo_pend = 1'b0;
  logic [3:0] modem_delta = '0;
  logic       out_en = 1'b1;
  logic       iir_rd = 1'b0;
  logic       ier_wr = 1'b0;
  logic       thr_wr = 1'b0;
  logic       tx_drain = 1'b0;
  logic [7:0] id_byte;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .line_stat(line_stat),
    .rx_count(rx_count), .rx_trig(rx_trig), .fifo_on(fifo_on),
    .tmo_pend(tmo_pend), .modem_delta(modem_delta), .out_en(out_en),
    .iir_rd(iir_rd), .ier_wr(ier_wr), .thr_wr(thr_wr), .tx_drain(tx_drain),
    .id_byte(id_byte), .irq(irq)
  );

  typedef struct packed {
    logic [3:0] ien;
    logic [5:0] lsr;
    logic [4:0] cnt;
    logic [4:0] trig;
    logic       fifo;
    logic       tmo;
    logic [3:0] msd;
    logic       oe;
    logic [7:0] exp_id;
    logic       exp_irq;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 6'h00, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h01, 1'b0, 4'd2},  // R2 idle
    '{4'h4, 6'h02, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h06, 1'b1, 4'd3},  // R3 overrun
    '{4'h4, 6'h10, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h06, 1'b1, 4'd3},  // R3 break
    '{4'h0, 6'h1E, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h01, 1'b0, 4'd3},  // R3 disabled
    '{4'h4, 6'h21, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h01, 1'b0, 4'd3},  // R3 outside mask
    '{4'h0, 6'h00, 5'd0,  5'd0,  1'b0, 1'b1, 4'h0, 1'b1, 8'h0C, 1'b1, 4'd12}, // R12 timeout ungated
    '{4'h4, 6'h02, 5'd0,  5'd0,  1'b0, 1'b1, 4'h0, 1'b1, 8'h06, 1'b1, 4'd1},  // R1 line over timeout
    '{4'h1, 6'h01, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h04, 1'b1, 4'd4},  // R4 no fifo
    '{4'h1, 6'h01, 5'd0,  5'd0,  1'b0, 1'b1, 4'h0, 1'b1, 8'h0C, 1'b1, 4'd1},  // R1 timeout over rx
    '{4'h1, 6'h01, 5'd3,  5'd4,  1'b1, 1'b0, 4'h0, 1'b1, 8'hC1, 1'b0, 4'd4},  // R4 below trig
    '{4'h1, 6'h01, 5'd4,  5'd4,  1'b1, 1'b0, 4'h0, 1'b1, 8'hC4, 1'b1, 4'd4},  // R4 at trig
    '{4'h1, 6'h01, 5'd13, 5'd14, 1'b1, 1'b0, 4'h0, 1'b1, 8'hC1, 1'b0, 4'd4},  // R4 one short
    '{4'h1, 6'h01, 5'd14, 5'd14, 1'b1, 1'b0, 4'h0, 1'b1, 8'hC4, 1'b1, 4'd4},  // R4 at 14
    '{4'h8, 6'h00, 5'd0,  5'd0,  1'b0, 1'b0, 4'h1, 1'b1, 8'h00, 1'b1, 4'd10}, // R10 delta
    '{4'h8, 6'h00, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b1, 8'h01, 1'b0, 4'd10}, // R10 no delta
    '{4'h0, 6'h00, 5'd0,  5'd0,  1'b0, 1'b0, 4'hF, 1'b1, 8'h01, 1'b0, 4'd10}, // R10 disabled
    '{4'h9, 6'h01, 5'd0,  5'd0,  1'b0, 1'b0, 4'h2, 1'b1, 8'h04, 1'b1, 4'd1},  // R1 rx over modem
    '{4'h9, 6'h01, 5'd1,  5'd4,  1'b1, 1'b0, 4'h2, 1'b1, 8'hC0, 1'b1, 4'd4},  // R4 lower reported
    '{4'h4, 6'h04, 5'd0,  5'd0,  1'b0, 1'b0, 4'h0, 1'b0, 8'h06, 1'b0, 4'd6},  // R6 out_en low
    '{4'h0, 6'h00, 5'd0,  5'd0,  1'b1, 1'b0, 4'h0, 1'b1, 8'hC1, 1'b0, 4'd5},  // R5 fifo idle
    '{4'h4, 6'h08, 5'd0,  5'd0,  1'b1, 1'b0, 4'h0, 1'b1, 8'hC6, 1'b1, 4'd5}   // R5 fifo line
  };

  task automatic check(input string rq, input logic [7:0] eid, input logic eirq);
    n_chk++;
    if (id_byte !== eid || irq !== eirq) begin
      n_bad++;
      $display("FAIL %s: id_byte=%02h irq=%0b expected id_byte=%02h irq=%0b",
               rq, id_byte, irq, eid, eirq);
    end
  endtask

  // Raise a strobe for one cycle; on return one rising edge has captured it
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: iir_rd = 1'b1;
      1: ier_wr = 1'b1;
      2: thr_wr = 1'b1;
      default: tx_drain = 1'b1;
    endcase
    @(negedge clk);
    iir_rd = 1'b0; ier_wr = 1'b0; thr_wr = 1'b0; tx_drain = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R13", 8'h01, 1'b0);  // R13 during reset
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R13", 8'h01, 1'b0);  // R13 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      int_en = VEC[i].ien; line_stat = VEC[i].lsr; rx_count = VEC[i].cnt;
      rx_trig = VEC[i].trig; fifo_on = VEC[i].fifo; tmo_pend = VEC[i].tmo;
      modem_delta = VEC[i].msd; out_en = VEC[i].oe;
      #1;
      check($sformatf("R%0d", VEC[i].rq), VEC[i].exp_id, VEC[i].exp_irq);
    end

    // Pending flag tests
    @(negedge clk);
    int_en = 4'h2; line_stat = 6'h20; rx_count = '0; rx_trig = '0;
    fifo_on = 1'b0; tmo_pend = 1'b0; modem_delta = '0; out_en = 1'b1;
    #1;
    check("R11", 8'h01, 1'b0);    // R11 flag clear after reset
    strobe(1);
    check("R8", 8'h02, 1'b1);     // R8 rearm with holder empty
    // R7 unchanged while the read strobe is high, cleared after
    @(negedge clk); iir_rd = 1'b1; #1;
    check("R7", 8'h02, 1'b1);
    @(negedge clk); iir_rd = 1'b0; #1;
    check("R7", 8'h01, 1'b0);
    line_stat = 6'h00;
    strobe(1);
    check("R8", 8'h01, 1'b0);     // R8 no rearm when holder busy
    strobe(3);
    check("R9", 8'h02, 1'b1);     // R9 drain sets
    strobe(2);
    check("R9", 8'h01, 1'b0);     // R9 holder write clears
    @(negedge clk); tx_drain = 1'b1; iir_rd = 1'b1;
    @(negedge clk); tx_drain = 1'b0; iir_rd = 1'b0; #1;
    check("R9", 8'h02, 1'b1);     // R9 set wins over clear
    int_en = 4'h0; #1;
    check("R11", 8'h01, 1'b0);    // R11 enable bit needed
    int_en = 4'h3; line_stat = 6'h01; #1;
    check("R1", 8'h04, 1'b1);     // R1 rx over transmit empty
    int_en = 4'hA; line_stat = 6'h00; modem_delta = 4'h4; #1;
    check("R1", 8'h02, 1'b1);     // R1 transmit empty over modem
    out_en = 1'b0; #1;
    check("R6", 8'h02, 1'b0);     // R6 gate
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule